// File: doc/BRIEF.md
# Dual-Window Display Memory Bank Mapper

This block turns CPU accesses that land in the 128 KB legacy display aperture (0xA0000 to 0xBFFFF) into 21-bit linear display-memory addresses, so that a CPU limited to 64 KB segments can reach a 2 MB frame store. It has two independent 64 KB windows. Window C always decodes the 0xA segment. Window D decodes the 0xB segment, unless the overlap mode is on, in which case it decodes the 0xA segment as well. Each window has its own 5-bit bank number.

In overlap mode a CPU read is steered through the window C bank and a CPU write through the window D bank. A block copy between two banks therefore needs only two register writes before it starts, not one bank change for every pixel moved. A 4-bit start offset, counted in 4 KB pages, is added to the translated address to shift where bank 0 begins. The offset lets software place a window across a bank boundary.

The configuration lives in a small indexed register file reached through a sequencer-style port pair. A write to the index port picks a register, and the data port then reads or writes that register. The CPU-side strobes are plain single-cycle pulses with no back-pressure, because the block only forwards one translated address per request.

Top module: `dwin_bank_mapper`

## Requirements
- R1: After reset the index register, the mode register (index 0x06), the start offset (index 0x07), both bank selects (indices 0x08 and 0x09) and the scratch registers (indices 0xE0 to 0xE2) all read 0x00, and `mem_hit` and `mem_we` are 0.
- R2: A write to I/O address 0x3C4 loads the 8-bit index. Reading I/O address 0x3C4 returns the index.
- R3: Index 0x07 holds the start offset in data bits 3:0. Bits 7:4 ignore writes and read back as 0.
- R4: Index 0x08 holds the window C bank and index 0x09 holds the window D bank, each in data bits 4:0. Bits 7:5 of both ignore writes and read back as 0.
- R5: Index 0x06 stores and returns all 8 bits, and its bit 1 is the overlap enable. Indices 0xE0, 0xE1 and 0xE2 store and return 8 bits and have no effect on translation. Any other index reads 0 at 0x3C5 and ignores writes.
- R6: With overlap off, a read or write to 0xA0000–0xAFFFF uses the window C bank and one to 0xB0000–0xBFFFF uses the window D bank. `mem_hit`, `mem_we` and `mem_addr` for an access appear on the clock edge that samples the strobe.
- R7: With overlap on, reads of 0xA0000–0xAFFFF use the window C bank, writes there use the window D bank, and accesses to 0xB0000–0xBFFFF miss.
- R8: The translated address is ({bank, cpu_addr[15:0]} + offset × 4096) modulo 2^21. Its bits 11:0 always equal cpu_addr[11:0].
- R9: With no strobe, or with an address outside every enabled window, `mem_hit` and `mem_we` are 0 and `mem_addr` is 0.
- R10: `io_rdata` is 0 whenever `io_addr` is neither 0x3C4 nor 0x3C5.
- R11: When `cpu_rd` and `cpu_wr` are asserted together, the access is treated as a write, and `mem_we` is 1 only when `mem_hit` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O port address |
| io_wr | input | 1 | I/O write strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | Combinational readback of the addressed port |
| cpu_addr | input | 20 | CPU memory address |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| mem_hit | output | 1 | Registered: the access fell in an enabled window |
| mem_we | output | 1 | Registered: the forwarded access is a write |
| mem_addr | output | 21 | Registered linear display-memory address |

## Verification
Register readback is combinational, so each readback check sets the port address on a falling edge and samples 1 ns later, with no clock edge in between. A register write takes effect at the rising edge that samples it. Translation results are due at the first rising edge after the strobe is driven, so each access task drives on the falling edge, waits one rising edge and samples 1 ns after it, then drops the strobe at the next falling edge. The expected addresses come from the modular-sum formula in R8, worked in the bench from the values it wrote. This includes the wrap from bank 31 with the largest offset.

// File: rtl/dwm_pkg.sv
package dwm_pkg;
  localparam int BANK_W = 5;
  localparam int OFF_W  = 4;
  localparam int LOW_W  = 16;
  localparam int PAGE_W = 12;
  localparam int SCR_N  = 3;

  localparam logic [15:0] PORT_INDEX = 16'h03C4;
  localparam logic [15:0] PORT_DATA  = 16'h03C5;

  localparam logic [7:0] IX_MODE   = 8'h06;
  localparam logic [7:0] IX_OFFSET = 8'h07;
  localparam logic [7:0] IX_BANK_C = 8'h08;
  localparam logic [7:0] IX_BANK_D = 8'h09;
  localparam logic [7:0] IX_SCR0   = 8'hE0;

  localparam logic [3:0] SEG_LO = 4'hA;
  localparam logic [3:0] SEG_HI = 4'hB;

  localparam int OVL_BIT = 1;
endpackage

// File: rtl/dwm_regfile.sv
module dwm_regfile
  import dwm_pkg::*;
#(
  parameter int BW = BANK_W,
  parameter int OW = OFF_W,
  parameter int NS = SCR_N
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   io_addr,
  input  logic          io_wr,
  input  logic [7:0]    io_wdata,
  output logic [7:0]    io_rdata,
  output logic [7:0]    idx_o,
  output logic          overlap_o,
  output logic [OW-1:0] off_o,
  output logic [BW-1:0] bank_c_o,
  output logic [BW-1:0] bank_d_o
);
  logic          wr_idx, wr_dat;
  logic [7:0]    idx_q, mode_q, dat_rd;
  logic [OW-1:0] off_q;
  logic [BW-1:0] bc_q, bd_q;
  logic [7:0]    scr_q [NS];

  assign wr_idx = io_wr && (io_addr == PORT_INDEX);
  assign wr_dat = io_wr && (io_addr == PORT_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      mode_q <= '0;
      off_q  <= '0;
      bc_q   <= '0;
      bd_q   <= '0;
    end else begin
      if (wr_idx) idx_q <= io_wdata;
      if (wr_dat) begin
        case (idx_q)
          IX_MODE:   mode_q <= io_wdata;
          IX_OFFSET: off_q  <= io_wdata[OW-1:0];
          IX_BANK_C: bc_q   <= io_wdata[BW-1:0];
          IX_BANK_D: bd_q   <= io_wdata[BW-1:0];
          default: ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NS; g++) begin : g_scr
    always_ff @(posedge clk) begin
      if (!rst_n) scr_q[g] <= '0;
      else if (wr_dat && idx_q == IX_SCR0 + 8'(g)) scr_q[g] <= io_wdata;
    end
  end

  always_comb begin
    dat_rd = '0;
    case (idx_q)
      IX_MODE:   dat_rd = mode_q;
      IX_OFFSET: dat_rd = {{(8-OW){1'b0}}, off_q};
      IX_BANK_C: dat_rd = {{(8-BW){1'b0}}, bc_q};
      IX_BANK_D: dat_rd = {{(8-BW){1'b0}}, bd_q};
      default: ;
    endcase
    for (int i = 0; i < NS; i++)
      if (idx_q == IX_SCR0 + 8'(i)) dat_rd = scr_q[i];
  end

  always_comb begin
    if (io_addr == PORT_INDEX)     io_rdata = idx_q;
    else if (io_addr == PORT_DATA) io_rdata = dat_rd;
    else                           io_rdata = '0;
  end

  assign idx_o     = idx_q;
  assign overlap_o = mode_q[OVL_BIT];
  assign off_o     = off_q;
  assign bank_c_o  = bc_q;
  assign bank_d_o  = bd_q;
endmodule

// File: rtl/dwm_win_sel.sv
module dwm_win_sel
  import dwm_pkg::*;
#(
  parameter int BW = BANK_W
) (
  input  logic [3:0]    seg,
  input  logic          rd,
  input  logic          wr,
  input  logic          overlap,
  input  logic [BW-1:0] bank_c,
  input  logic [BW-1:0] bank_d,
  output logic          hit,
  output logic [BW-1:0] bank
);
  localparam int NWIN = 2;
  logic [3:0]    base  [NWIN];
  logic [NWIN-1:0] match;
  logic          use_d;

  assign base[0] = SEG_LO;
  assign base[1] = overlap ? SEG_LO : SEG_HI;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    assign match[w] = (seg == base[w]);
  end

  // window D wins a shared segment only for writes
  assign use_d = match[1] && (!match[0] || wr);
  assign hit   = (rd || wr) && (|match);
  assign bank  = use_d ? bank_d : bank_c;
endmodule

// File: rtl/dwm_addr_xlat.sv
module dwm_addr_xlat
  import dwm_pkg::*;
#(
  parameter int BW = BANK_W,
  parameter int OW = OFF_W,
  parameter int LW = LOW_W,
  parameter int PW = PAGE_W
) (
  input  logic [BW-1:0]    bank,
  input  logic [LW-1:0]    low,
  input  logic [OW-1:0]    off,
  output logic [BW+LW-1:0] lin
);
  localparam int AW = BW + LW;
  logic [AW-1:0] page_add;

  assign page_add = AW'(off) << PW;
  assign lin      = {bank, low} + page_add;
endmodule

// File: rtl/dwin_bank_mapper.sv
module dwin_bank_mapper
  import dwm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] io_addr,
  input  logic        io_wr,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  input  logic [19:0] cpu_addr,
  input  logic        cpu_rd,
  input  logic        cpu_wr,
  output logic        mem_hit,
  output logic        mem_we,
  output logic [20:0] mem_addr
);
  localparam int AW = BANK_W + LOW_W;

  logic [7:0]        cur_idx;
  logic              ovl_mode;
  logic [OFF_W-1:0]  start_off;
  logic [BANK_W-1:0] bank_c, bank_d, sel_bank;
  logic              win_hit;
  logic [AW-1:0]     lin_addr;

  dwm_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .idx_o(cur_idx),
    .overlap_o(ovl_mode), .off_o(start_off), .bank_c_o(bank_c),
    .bank_d_o(bank_d)
  );

  dwm_win_sel u_sel (
    .seg(cpu_addr[19:16]), .rd(cpu_rd), .wr(cpu_wr), .overlap(ovl_mode),
    .bank_c(bank_c), .bank_d(bank_d), .hit(win_hit), .bank(sel_bank)
  );

  dwm_addr_xlat u_xlat (
    .bank(sel_bank), .low(cpu_addr[LOW_W-1:0]), .off(start_off),
    .lin(lin_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_hit  <= 1'b0;
      mem_we   <= 1'b0;
      mem_addr <= '0;
    end else begin
      mem_hit  <= win_hit;
      mem_we   <= win_hit && cpu_wr;
      mem_addr <= win_hit ? lin_addr : '0;
    end
  end
endmodule

// File: rtl/dwm_checker.sv
module dwm_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] io_addr,
  input logic [7:0]  io_rdata,
  input logic [7:0]  cur_idx,
  input logic        ovl_mode,
  input logic [19:0] cpu_addr,
  input logic        cpu_rd,
  input logic        cpu_wr,
  input logic        mem_hit,
  input logic        mem_we,
  input logic [20:0] mem_addr
);
  logic req;
  assign req = cpu_rd || cpu_wr;

  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> (!mem_hit && !mem_we && mem_addr == '0));

  a_r9_outside: assert property (@(posedge clk) disable iff (!rst_n)
    (req && cpu_addr[19:17] != 3'b101) |=> !mem_hit);

  a_r6_hi_seg_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (req && cpu_addr[19:16] == 4'hB && !ovl_mode) |=> mem_hit);

  a_r7_hi_seg_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (req && cpu_addr[19:16] == 4'hB && ovl_mode) |=> !mem_hit);

  a_r11_we_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_hit);

  a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[19:16] == 4'hA) |=> mem_we);

  a_r8_page_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (req && cpu_addr[19:16] == 4'hA) |=> mem_addr[11:0] == $past(cpu_addr[11:0]));

  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (io_addr == 16'h03C5 && cur_idx == 8'h07) |-> io_rdata[7:4] == 4'h0);

  a_r10_other_port: assert property (@(posedge clk) disable iff (!rst_n)
    (io_addr != 16'h03C4 && io_addr != 16'h03C5) |-> io_rdata == 8'h00);
endmodule

bind dwin_bank_mapper dwm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rdata(io_rdata),
  .cur_idx(cur_idx), .ovl_mode(ovl_mode), .cpu_addr(cpu_addr),
  .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .mem_hit(mem_hit), .mem_we(mem_we),
  .mem_addr(mem_addr)
);

// File: tb/dwin_bank_mapper_tb.sv
`timescale 1ns/1ps
module dwin_bank_mapper_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic [19:0] cpu_addr = '0;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic        mem_hit, mem_we;
  logic [20:0] mem_addr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dwin_bank_mapper u_dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .cpu_addr(cpu_addr),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .mem_hit(mem_hit), .mem_we(mem_we),
    .mem_addr(mem_addr)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [20:0] xl(input logic [4:0] bank, input logic [19:0] a,
                                     input logic [3:0] off);
    logic [21:0] s;
    s = {1'b0, bank, a[15:0]} + (22'(off) << 12);
    return s[20:0];
  endfunction

  task automatic io_put(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic reg_put(input logic [7:0] ix, input logic [7:0] d);
    io_put(16'h03C4, ix);
    io_put(16'h03C5, d);
  endtask

  task automatic reg_chk(input logic [7:0] ix, input logic [7:0] exp, input string rq);
    io_put(16'h03C4, ix);
    @(negedge clk);
    io_addr = 16'h03C5;
    #1;
    chk(io_rdata == exp, rq, $sformatf("readback idx 0x%0h", ix), io_rdata, exp);
  endtask

  task automatic cpu_chk(input logic [19:0] a, input bit rd, input bit wr,
                         input bit eh, input bit ew, input logic [20:0] ea,
                         input string rq);
    @(negedge clk);
    cpu_addr = a; cpu_rd = rd; cpu_wr = wr;
    @(posedge clk);
    #1;
    chk(mem_hit == eh, rq, $sformatf("mem_hit @0x%0h", a), 32'(mem_hit), 32'(eh));
    chk(mem_we == ew, rq, $sformatf("mem_we @0x%0h", a), 32'(mem_we), 32'(ew));
    chk(mem_addr == ea, rq, $sformatf("mem_addr @0x%0h", a), 32'(mem_addr), 32'(ea));
    @(negedge clk);
    cpu_rd = 1'b0; cpu_wr = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    chk(mem_hit == 1'b0 && mem_we == 1'b0, "R1", "outputs after reset",
        {mem_hit, mem_we}, 0);
    @(negedge clk);
    io_addr = 16'h03C4; #1;
    chk(io_rdata == 8'h00, "R1", "index after reset", io_rdata, 0);
    foreach (ix_list[i]) reg_chk(ix_list[i], 8'h00, "R1");
  endtask

  logic [7:0] ix_list [7] = '{8'h06, 8'h07, 8'h08, 8'h09, 8'hE0, 8'hE1, 8'hE2};

  task automatic t_index;
    io_put(16'h03C4, 8'h5C);
    @(negedge clk); io_addr = 16'h03C4; #1;
    chk(io_rdata == 8'h5C, "R2", "index readback", io_rdata, 8'h5C);
  endtask

  task automatic t_fields;
    reg_put(8'h07, 8'hF9); reg_chk(8'h07, 8'h09, "R3");
    reg_put(8'h08, 8'hFF); reg_chk(8'h08, 8'h1F, "R4");
    reg_put(8'h09, 8'hEA); reg_chk(8'h09, 8'h0A, "R4");
    reg_put(8'h06, 8'hA5); reg_chk(8'h06, 8'hA5, "R5");
    reg_put(8'hE0, 8'h3C); reg_put(8'hE1, 8'hC3); reg_put(8'hE2, 8'h81);
    reg_chk(8'hE0, 8'h3C, "R5"); reg_chk(8'hE1, 8'hC3, "R5"); reg_chk(8'hE2, 8'h81, "R5");
    reg_put(8'h10, 8'h77); reg_chk(8'h10, 8'h00, "R5");
    @(negedge clk); io_addr = 16'h03C6; #1;
    chk(io_rdata == 8'h00, "R10", "other io port", io_rdata, 0);
  endtask

  task automatic t_split;
    reg_put(8'h06, 8'h00); reg_put(8'h07, 8'h00);
    reg_put(8'h08, 8'h03); reg_put(8'h09, 8'h11);
    // scratch writes must leave translation alone
    reg_put(8'hE1, 8'hFF);
    cpu_chk(20'hA1234, 1, 0, 1, 0, xl(5'h03, 20'hA1234, 0), "R6");
    cpu_chk(20'hBFFFF, 0, 1, 1, 1, xl(5'h11, 20'hBFFFF, 0), "R6");
    cpu_chk(20'hB0000, 1, 0, 1, 0, xl(5'h11, 20'hB0000, 0), "R6");
    cpu_chk(20'hAFFFF, 1, 1, 1, 1, xl(5'h03, 20'hAFFFF, 0), "R11");
  endtask

  task automatic t_offset;
    reg_put(8'h07, 8'h05);
    cpu_chk(20'hA0ABC, 1, 0, 1, 0, xl(5'h03, 20'hA0ABC, 4'h5), "R8");
    reg_put(8'h08, 8'h1F); reg_put(8'h07, 8'h0F);
    cpu_chk(20'hAFFFF, 1, 0, 1, 0, 21'h00EFFF, "R8");
  endtask

  task automatic t_overlap;
    reg_put(8'h07, 8'h00); reg_put(8'h08, 8'h02); reg_put(8'h09, 8'h07);
    reg_put(8'h06, 8'h02);
    cpu_chk(20'hA4000, 1, 0, 1, 0, xl(5'h02, 20'hA4000, 0), "R7");
    cpu_chk(20'hA4000, 0, 1, 1, 1, xl(5'h07, 20'hA4000, 0), "R7");
    cpu_chk(20'hB4000, 1, 0, 0, 0, 21'h0, "R7");
    cpu_chk(20'hB4000, 0, 1, 0, 0, 21'h0, "R7");
    reg_put(8'h06, 8'hFD);
    cpu_chk(20'hB0010, 1, 0, 1, 0, xl(5'h07, 20'hB0010, 0), "R5");
  endtask

  task automatic t_miss;
    cpu_chk(20'h9FFFF, 1, 0, 0, 0, 21'h0, "R9");
    cpu_chk(20'hC0000, 0, 1, 0, 0, 21'h0, "R9");
    cpu_chk(20'hA0000, 0, 0, 0, 0, 21'h0, "R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_index();
    t_fields();
    t_split();
    t_offset();
    t_overlap();
    t_miss();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule